// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This block accepts a stream of received frame bytes and stores them in memory buffers. Software describes the buffers through a ring of descriptors, and the engine walks that ring. Each descriptor takes four consecutive 16-bit memory words. The engine reads a descriptor's status word to learn whether software has made the buffer available. It fills the buffer byte by byte. When it closes the buffer, it writes the byte count and then a new status word. That status write hands the buffer back to software. If the descriptor asks for it, the engine also pulses an interrupt.

A frame may spread over several buffers. A buffer closes when the frame ends, when the frame is aborted, or when it reaches the configured maximum length. Flags in the status word show which buffer starts a frame and which one ends it. A wrap flag marks the last descriptor and sends the engine back to the ring base. In continuous mode a descriptor remains owned by the engine after it is filled. If a frame needs a buffer and none is available, the rest of that frame is discarded and a sticky error flag is raised.

Byte stream and memory share one clock. The memory port is word wide, has byte enables and returns read data one cycle after the request. Every accepted byte is processed completely before the next one is taken. The engine therefore stalls the stream with `rx_ready`.

Top module: `bd_rx_engine`

## Requirements
- R1: Descriptor layout and byte placement.
  - Word layout: a descriptor at word address D holds status at D, data length at D+1, pointer high half at D+2 and pointer low half at D+3.
  - Byte address: the buffer byte address is {high, low}; byte k of the buffer goes to byte address base+k.
  - Word addressing: that byte is stored at memory word (address>>1).
  - Lane selection: an even byte address uses bits 15:8 (mem_be=2'b10) and an odd one uses bits 7:0 (mem_be=2'b01).
- R2: Ownership by status bit 15 (E).
  - The engine stores frame bytes only into a buffer whose status word had E=1 when it was opened.
  - On closing a buffer the engine writes E=0, unless R8 applies.
- R3: Ring walk. After closing a descriptor with status bit 13 (W) set, the next descriptor used is at cfg_ring_base. Otherwise the next descriptor is at the current address plus 4 words.
- R4: Interrupt. Closing a descriptor whose status bit 12 (I) is set produces exactly one single-cycle pulse on bd_irq. Closing a descriptor with I=0 produces none.
- R5: Frame marks in the written status word.
  - Status bit 10 (F) is set on the buffer that holds the first byte of a frame.
  - Status bit 11 (L) is set on the buffer that holds the last byte of a frame.
  - Bits W, I and bit 9 (C) are copied from the status word as read; all other bits are written 0.
- R6: Buffer full. A buffer closes without L when its count reaches cfg_max_len. The frame continues in the next descriptor, without F. A buffer never holds bytes of two frames.
- R7: Abort. A beat with rx_abort closes an open buffer with its count and without L. Beats without rx_sof that follow, outside a frame, are ignored. The next frame's first buffer gets F.
- R8: Continuous mode. Closing a descriptor whose C bit (9) is set writes E=1 in the new status word.
- R9: Length. The data length word receives the number of bytes stored in the buffer, and it is written before the status word.
- R10: No buffer. If a frame needs a buffer and the current descriptor has E=0:
  - Discard: the rest of that frame is discarded with no memory write.
  - No advance: the descriptor is not advanced.
  - Sticky flag: no_buf_err goes high and stays high until reset.
- R11: After reset: rx_ready is 1, bd_irq is 0, no_buf_err is 0 and mem_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the ring base as current descriptor |
| cfg_ring_base | input | AW | Word address of the first descriptor |
| cfg_max_len | input | 16 | Maximum bytes per buffer (at least 1) |
| rx_valid | input | 1 | Stream beat valid |
| rx_ready | output | 1 | Engine can accept a beat |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | Beat carries the first byte of a frame |
| rx_eof | input | 1 | Beat carries the last byte of a frame |
| rx_abort | input | 1 | Beat aborts the current frame (no data) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_be | output | 2 | Byte enables, bit 1 = bits 15:8 |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| bd_irq | output | 1 | Buffer hand-back interrupt pulse |
| no_buf_err | output | 1 | Sticky flag: a frame found no available buffer |

## Verification
The assertions rely on three conditions holding:
- Configuration: the ring base and the maximum length are stable while a buffer is open.
- Stream order: every frame opens with rx_sof, and no new rx_sof arrives before the previous frame has ended with rx_eof or rx_abort.
- Memory: read data follows the request by exactly one cycle.

The bench keeps to these conditions in three ways:
- Configuration and re-arming happen only between frames, when the engine is idle and no buffer is open.
- Every frame is closed by either an end mark or an abort.
- The bench memory model answers reads with a one-cycle registered read.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

    // Status word bit positions
    localparam int ST_E = 15;
    localparam int ST_W = 13;
    localparam int ST_I = 12;
    localparam int ST_L = 11;
    localparam int ST_F = 10;
    localparam int ST_C = 9;

    // Word offsets inside one descriptor
    localparam int OFS_STAT = 0;
    localparam int OFS_LEN  = 1;
    localparam int OFS_PHI  = 2;
    localparam int OFS_PLO  = 3;
    localparam int DESC_WORDS = 4;

    typedef struct packed {
        logic [7:0] data;
        logic       sof;
        logic       eof;
        logic       abort;
    } rx_beat_t;

    typedef enum logic [3:0] {
        S_WAIT,
        S_DECIDE,
        S_ST_RD,
        S_ST_CAP,
        S_PH_RD,
        S_PH_CAP,
        S_PL_RD,
        S_PL_CAP,
        S_WR_BYTE,
        S_WR_LEN,
        S_WR_STAT
    } eng_state_t;

    // Status word written when a buffer is handed back
    function automatic logic [15:0] close_status(input logic [15:0] orig,
                                                 input logic first,
                                                 input logic last);
        logic [15:0] s;
        s       = '0;
        s[ST_W] = orig[ST_W];
        s[ST_I] = orig[ST_I];
        s[ST_C] = orig[ST_C];
        s[ST_E] = orig[ST_C];
        s[ST_F] = first;
        s[ST_L] = last;
        return s;
    endfunction

endpackage

// File: rtl/rxbd_beat_reg.sv
module rxbd_beat_reg
    import rxbd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    output logic     in_ready,
    input  rx_beat_t in_beat,
    input  logic     take,
    output logic     held,
    output rx_beat_t beat
);

    assign in_ready = !held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            beat <= '0;
        end else if (take) begin
            held <= 1'b0;
        end else if (in_valid && !held) begin
            held <= 1'b1;
            beat <= in_beat;
        end
    end

    // A held beat stays unchanged until the engine consumes it
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (held && !take) |=> (held && $stable(beat)));

endmodule

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr
    import rxbd_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] desc_addr
);

    localparam logic [AW-1:0] STEP = AW'(DESC_WORDS);

    always_ff @(posedge clk) begin
        if (rst)
            desc_addr <= base;
        else if (advance)
            desc_addr <= wrap ? base : desc_addr + STEP;
    end

    p_wrap_to_base_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && wrap) |=> (desc_addr == $past(base)));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && !wrap) |=> (desc_addr == $past(desc_addr) + STEP));

endmodule

// File: rtl/rxbd_fsm.sv
module rxbd_fsm
    import rxbd_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          held,
    input  rx_beat_t      beat,
    input  logic [15:0]   max_len,
    input  logic [AW-1:0] desc_addr,
    input  logic [15:0]   mem_rdata,
    output logic          take,
    output logic          advance,
    output logic          wrap,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic [15:0]   mem_wdata,
    output logic          irq,
    output logic          ovr
);

    localparam int BW = AW + 1;

    eng_state_t     state;
    logic           in_frame, dropping, buf_open;
    logic           next_first, cur_first, close_last;
    logic [15:0]    stat_q, ptr_hi, cnt_q;
    logic [BW-1:0]  ptr_q, byte_addr;
    logic           irq_q, ovr_q;
    logic           in_pkt, drop_now, buf_full;

    assign byte_addr = ptr_q + BW'(cnt_q);
    assign in_pkt    = beat.sof || in_frame;
    assign drop_now  = dropping && !beat.sof;
    assign buf_full  = (cnt_q + 16'd1) == max_len;
    assign irq       = irq_q;
    assign ovr       = ovr_q;

    always_comb begin
        take      = 1'b0;
        advance   = 1'b0;
        wrap      = stat_q[ST_W];
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_be    = 2'b11;
        mem_wdata = '0;
        unique case (state)
            S_DECIDE: begin
                if (beat.abort)   take = !buf_open;
                else if (!in_pkt) take = 1'b1;
                else if (drop_now) take = 1'b1;
            end
            S_ST_RD: mem_req = 1'b1;
            S_ST_CAP: take = !mem_rdata[ST_E];
            S_PH_RD: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(OFS_PHI);
            end
            S_PL_RD: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(OFS_PLO);
            end
            S_WR_BYTE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_addr[BW-1:1];
                mem_be    = byte_addr[0] ? 2'b01 : 2'b10;
                mem_wdata = {beat.data, beat.data};
                take      = !beat.eof && !buf_full;
            end
            S_WR_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + AW'(OFS_LEN);
                mem_wdata = cnt_q;
            end
            S_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + AW'(OFS_STAT);
                mem_wdata = close_status(stat_q, cur_first, close_last);
                take      = 1'b1;
                advance   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_WAIT;
            in_frame   <= 1'b0;
            dropping   <= 1'b0;
            buf_open   <= 1'b0;
            next_first <= 1'b1;
            cur_first  <= 1'b0;
            close_last <= 1'b0;
            stat_q     <= '0;
            ptr_hi     <= '0;
            ptr_q      <= '0;
            cnt_q      <= '0;
            irq_q      <= 1'b0;
            ovr_q      <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state)
                S_WAIT: if (held) state <= S_DECIDE;
                S_DECIDE: begin
                    if (beat.abort) begin
                        in_frame   <= 1'b0;
                        dropping   <= 1'b0;
                        next_first <= 1'b1;
                        close_last <= 1'b0;
                        state      <= buf_open ? S_WR_LEN : S_WAIT;
                    end else if (!in_pkt) begin
                        state <= S_WAIT;
                    end else begin
                        if (beat.sof) begin
                            in_frame   <= 1'b1;
                            dropping   <= 1'b0;
                            next_first <= 1'b1;
                        end
                        if (drop_now) begin
                            if (beat.eof) begin
                                in_frame <= 1'b0;
                                dropping <= 1'b0;
                            end
                            state <= S_WAIT;
                        end else begin
                            state <= buf_open ? S_WR_BYTE : S_ST_RD;
                        end
                    end
                end
                S_ST_RD: state <= S_ST_CAP;
                S_ST_CAP: begin
                    stat_q <= mem_rdata;
                    if (!mem_rdata[ST_E]) begin
                        ovr_q <= 1'b1;
                        if (beat.eof) in_frame <= 1'b0;
                        else          dropping <= 1'b1;
                        state <= S_WAIT;
                    end else begin
                        state <= S_PH_RD;
                    end
                end
                S_PH_RD:  state <= S_PH_CAP;
                S_PH_CAP: begin
                    ptr_hi <= mem_rdata;
                    state  <= S_PL_RD;
                end
                S_PL_RD:  state <= S_PL_CAP;
                S_PL_CAP: begin
                    ptr_q      <= BW'({ptr_hi, mem_rdata});
                    cnt_q      <= '0;
                    buf_open   <= 1'b1;
                    cur_first  <= next_first;
                    next_first <= 1'b0;
                    state      <= S_WR_BYTE;
                end
                S_WR_BYTE: begin
                    cnt_q <= cnt_q + 16'd1;
                    if (beat.eof) begin
                        in_frame   <= 1'b0;
                        close_last <= 1'b1;
                        state      <= S_WR_LEN;
                    end else if (buf_full) begin
                        close_last <= 1'b0;
                        state      <= S_WR_LEN;
                    end else begin
                        state <= S_WAIT;
                    end
                end
                S_WR_LEN: state <= S_WR_STAT;
                S_WR_STAT: begin
                    irq_q    <= stat_q[ST_I];
                    buf_open <= 1'b0;
                    state    <= S_WAIT;
                end
                default: state <= S_WAIT;
            endcase
        end
    end

    // R4: an interrupt is a lone pulse
    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R10: the error flag never falls outside reset
    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        ovr |=> ovr);

    // R6: the buffer count never exceeds the limit
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        buf_open |-> (cnt_q <= max_len));

    // R9: the length word write is immediately followed by the status write
    p_len_then_stat_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_we && state == S_WR_LEN) |=> (mem_we && mem_addr == desc_addr));

    // R2: byte stores only go into an opened buffer
    p_store_needs_buf_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_we && state == S_WR_BYTE) |-> buf_open);

endmodule

// File: rtl/bd_rx_engine.sv
module bd_rx_engine
    import rxbd_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_ring_base,
    input  logic [15:0]   cfg_max_len,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [7:0]    rx_data,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic          rx_abort,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          bd_irq,
    output logic          no_buf_err
);

    rx_beat_t      in_beat, beat;
    logic          held, take, advance, wrap;
    logic [AW-1:0] desc_addr;

    assign in_beat = '{data: rx_data, sof: rx_sof, eof: rx_eof, abort: rx_abort};

    rxbd_beat_reg u_beat (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_valid),
        .in_ready (rx_ready),
        .in_beat  (in_beat),
        .take     (take),
        .held     (held),
        .beat     (beat)
    );

    rxbd_ring_ptr #(.AW(AW)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .base      (cfg_ring_base),
        .advance   (advance),
        .wrap      (wrap),
        .desc_addr (desc_addr)
    );

    rxbd_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .held      (held),
        .beat      (beat),
        .max_len   (cfg_max_len),
        .desc_addr (desc_addr),
        .mem_rdata (mem_rdata),
        .take      (take),
        .advance   (advance),
        .wrap      (wrap),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .irq       (bd_irq),
        .ovr       (no_buf_err)
    );

    // R11: while a beat can be taken the engine is idle on memory
    p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> !mem_req);

endmodule

// File: tb/tb_bd_rx_engine.sv
module tb_bd_rx_engine;

    localparam int AW       = 12;
    localparam int NWORDS   = 1 << AW;
    localparam int NDESC    = 4;
    localparam int RING     = 16;
    localparam int BUF_WORD = 'h800;
    localparam int BUF_SPAN = 'h40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [AW-1:0] cfg_ring_base = AW'(RING);
    logic [15:0]   cfg_max_len   = 16'd8;
    logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_abort = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_ready, mem_req, mem_we, bd_irq, no_buf_err;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_be;
    logic [15:0]   mem_wdata, mem_rdata;

    bd_rx_engine #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .cfg_ring_base(cfg_ring_base), .cfg_max_len(cfg_max_len),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_abort(rx_abort), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .bd_irq(bd_irq), .no_buf_err(no_buf_err)
    );

    logic [15:0] mem [NWORDS];
    logic [15:0] exp_mem [NWORDS];
    int n_checks = 0, n_fail = 0, irq_seen = 0;

    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
        if (mem_req && mem_we) begin
            if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
            if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
        end
        if (!rst && bd_irq) irq_seen++;
    end

    // Reference model state
    int m_idx = 0, m_cnt = 0, m_irq = 0;
    bit m_open = 0, m_first = 1, m_cur_first = 0, m_drop = 0, m_inframe = 0, m_ovr = 0;
    int unsigned m_ptr = 0;

    task automatic check(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic model_close(input bit last);
        int da;
        logic [15:0] st, ns;
        da = RING + m_idx * 4;
        st = exp_mem[da];
        ns = '0;
        ns[13] = st[13]; ns[12] = st[12]; ns[9] = st[9];
        ns[15] = st[9];  ns[10] = m_cur_first; ns[11] = last;
        exp_mem[da + 1] = 16'(m_cnt);
        exp_mem[da]     = ns;
        if (st[12]) m_irq++;
        m_idx  = st[13] ? 0 : m_idx + 1;
        m_open = 0;
    endtask

    task automatic model_beat(input logic [7:0] d, input bit sof, input bit eof, input bit ab);
        int da;
        int unsigned ba;
        da = RING + m_idx * 4;
        if (ab) begin
            m_inframe = 0; m_drop = 0; m_first = 1;
            if (m_open) model_close(0);
            return;
        end
        if (!(sof || m_inframe)) return;
        if (sof) begin m_inframe = 1; m_drop = 0; m_first = 1; end
        if (m_drop) begin
            if (eof) begin m_inframe = 0; m_drop = 0; end
            return;
        end
        if (!m_open) begin
            if (!exp_mem[da][15]) begin
                m_ovr = 1;
                if (eof) m_inframe = 0; else m_drop = 1;
                return;
            end
            m_open = 1; m_cnt = 0; m_cur_first = m_first; m_first = 0;
            m_ptr = {exp_mem[da + 2], exp_mem[da + 3]};
        end
        ba = m_ptr + m_cnt;
        if (ba[0]) exp_mem[ba >> 1][7:0]  = d;
        else       exp_mem[ba >> 1][15:8] = d;
        m_cnt++;
        if (eof) begin m_inframe = 0; model_close(1); end
        else if (m_cnt == int'(cfg_max_len)) model_close(0);
    endtask

    task automatic beat(input logic [7:0] d, input bit sof, input bit eof, input bit ab);
        model_beat(d, sof, eof, ab);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1; rx_data = d; rx_sof = sof; rx_eof = eof; rx_abort = ab;
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_abort = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input int n, input int abort_after);
        for (int k = 0; k < n; k++) begin
            if (abort_after >= 0 && k == abort_after) begin
                beat(8'h00, 0, 0, 1);
                return;
            end
            beat(8'($urandom), k == 0, k == n - 1, 0);
        end
    endtask

    task automatic arm(input bit [3:0] e_m, input bit [3:0] i_m, input bit [3:0] c_m);
        for (int k = 0; k < NDESC; k++) begin
            logic [15:0] st;
            int unsigned pb;
            st = '0;
            st[15] = e_m[k]; st[12] = i_m[k]; st[9] = c_m[k]; st[13] = (k == NDESC - 1);
            pb = 32'((BUF_WORD + k * BUF_SPAN) * 2);
            mem[RING + k*4] = st;           exp_mem[RING + k*4] = st;
            mem[RING + k*4 + 1] = '0;       exp_mem[RING + k*4 + 1] = '0;
            mem[RING + k*4 + 2] = pb[31:16]; exp_mem[RING + k*4 + 2] = pb[31:16];
            mem[RING + k*4 + 3] = pb[15:0];  exp_mem[RING + k*4 + 3] = pb[15:0];
        end
    endtask

    task automatic compare_all(input string tag);
        for (int w = RING; w < RING + NDESC * 4; w++) check(tag, mem[w], exp_mem[w]);
        for (int w = BUF_WORD; w < BUF_WORD + NDESC * BUF_SPAN; w++) check(tag, mem[w], exp_mem[w]);
        check({tag, " irq count"}, irq_seen, m_irq);
        check({tag, " error flag"}, no_buf_err, m_ovr);
    endtask

    initial begin
        #(120000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd5150);
        for (int w = 0; w < NWORDS; w++) begin mem[w] = '0; exp_mem[w] = '0; end
        mem_rdata = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        check("R11 rx_ready", rx_ready, 1);
        check("R11 bd_irq", bd_irq, 0);
        check("R11 no_buf_err", no_buf_err, 0);
        check("R11 mem_req", mem_req, 0);

        // R1 R5 R9 R4: three byte frame in desc0
        arm(4'hF, 4'hF, 4'h0);
        beat(8'hA1, 1, 0, 0); beat(8'hB2, 0, 0, 0); beat(8'hC3, 0, 1, 0);
        wait_idle();
        check("R5 R2 status F|L|I, E clear", mem[RING], 16'h1C00);
        check("R9 length", mem[RING + 1], 3);
        check("R1 even/odd lanes", mem[BUF_WORD], 16'hA1B2);
        check("R1 third byte high lane", mem[BUF_WORD + 1][15:8], 8'hC3);
        check("R4 one pulse", irq_seen, 1);
        compare_all("R1 single frame");

        // R6: exactly max length
        frame(8, -1); wait_idle();
        check("R6 full single buffer", mem[RING + 4], 16'h1C00);
        check("R6 length max", mem[RING + 5], 8);
        compare_all("R6 exact fit");

        // R3 R6: spans three buffers and wraps
        arm(4'hF, 4'hF, 4'h0);
        frame(20, -1); wait_idle();
        check("R6 first part F only", mem[RING + 8], 16'h1400);
        check("R3 wrap desc keeps W", mem[RING + 12], 16'h3000);
        check("R3 wrapped to base, L", mem[RING], 16'h1800);
        check("R9 tail length", mem[RING + 1], 4);
        compare_all("R3 spanning frame");

        // R7: abort, stray bytes, then new frame with F
        arm(4'hF, 4'hF, 4'h0);
        frame(9, 5);
        beat(8'h55, 0, 0, 0); beat(8'h66, 0, 1, 0);
        frame(2, -1); wait_idle();
        check("R7 aborted buffer no L", mem[RING + 4], 16'h1400);
        check("R7 aborted length", mem[RING + 5], 5);
        check("R7 next frame gets F", mem[RING + 8], 16'h1C00);
        compare_all("R7 abort");

        // R8: continuous mode keeps E, no interrupt with I clear
        arm(4'hF, 4'h0, 4'hF);
        frame(3, -1); wait_idle();
        check("R8 E kept", mem[RING + 12], 16'hAE00);
        compare_all("R8 continuous");

        // R10: no buffer available
        arm(4'h0, 4'hF, 4'h0);
        frame(4, -1); wait_idle();
        check("R10 flag set", no_buf_err, 1);
        compare_all("R10 dropped frame");
        arm(4'hF, 4'hF, 4'h0);
        frame(2, -1); wait_idle();
        check("R10 same descriptor reused", mem[RING], 16'h1C00);
        check("R10 flag sticky", no_buf_err, 1);
        compare_all("R10 recovery");

        // Random frames
        for (int t = 0; t < 60; t++) begin
            int n;
            int ab;
            cfg_max_len = 16'(1 + $urandom_range(0, 11));
            arm(4'($urandom | $urandom), 4'($urandom), 4'($urandom_range(0, 15) & 4'($urandom)));
            n  = 1 + $urandom_range(0, 29);
            ab = ($urandom_range(0, 7) == 0) ? $urandom_range(0, n - 1) : -1;
            frame(n, ab);
            if ($urandom_range(0, 3) == 0) beat(8'h77, 0, 0, 0);
            wait_idle();
            compare_all("R2 R3 R5 R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule